// File: doc/BRIEF.md
# DRAM Bank State Tracker

This block follows the state of every bank of a graphics DRAM from the controller side. It watches the decoded command stream that the controller issues, one command per clock. The commands are activate, read, write, precharge, auto refresh, self-refresh entry and self-refresh exit. With each command it sees the bank address and the auto-precharge address bit. For every bank it decides whether a row is open, whether the bank is closing, and whether an activate may be issued to it now. The closing state is timed with a row-precharge countdown.

Every command is judged against that state. A command that breaks a rule raises a one-cycle error pulse that carries a reason code. The command is still echoed on the monitor outputs, and it leaves the bank state untouched. A precharge aimed at a bank with nothing to close is a harmless no-op. After self-refresh exit, reads are locked out for a parameterised number of cycles. All timings are parameters, counted in clock cycles.

Top module: `dram_bank_tracker`

## Requirements
- R1: While reset is high, and in the first cycle after it, no bank is active, every bank is ready for activate, all_idle is high, rd_locked is low and no error is flagged.
- R2: An activate (cmd 1) to a bank that is ready makes its bank_active bit high in the next cycle. An activate to a bank whose row is open gives error code 1.
- R3: A precharge (cmd 4) with a8 low to an open bank clears its active bit and its ready bit in the next cycle. The bank becomes ready again so that an activate sampled T_RP edges after the precharge edge is legal. An activate to the bank before that gives error code 3.
- R4: A precharge with a8 high starts closing every bank whose row is open, whatever the bank address.
- R5: A precharge to a bank that is idle or already closing raises no error and does not restart that bank's countdown.
- R6: A read (cmd 2) or write (cmd 3) to a bank without an open row gives error code 2.
- R7: A write with a8 high to an open bank keeps the row open, then begins closing it T_WRAP edges after the write edge. The bank becomes ready T_RP edges after that.
- R8: Auto refresh (cmd 5) or self-refresh entry (cmd 6) while any bank is not ready gives error code 1.
- R9: After self-refresh exit (cmd 7), rd_locked is high, and any read sampled fewer than T_SRX edges after the exit edge gives error code 4. This code takes precedence over code 2.
- R10: err_o and err_code_o, together with the echo of cmd, bank and a8 on the monitor outputs, appear in the cycle after the command edge. err_o lasts exactly that one cycle. Code 0 means no error.
- R11: A command that raises an error changes no bank state.
- R12: all_idle is high exactly when every bank is ready for activate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| cmd_i | input | 3 | 0 nop, 1 activate, 2 read, 3 write, 4 precharge, 5 auto refresh, 6 self-refresh entry, 7 self-refresh exit |
| ba_i | input | 3 | bank address |
| a8_i | input | 1 | auto-precharge / precharge-all bit |
| err_o | output | 1 | one-cycle error pulse |
| err_code_o | output | 3 | 0 none, 1 bank not idle, 2 bank not active, 3 precharge time pending, 4 read locked out |
| mon_cmd_o | output | 3 | registered echo of the command |
| mon_ba_o | output | 3 | registered echo of the bank address |
| mon_a8_o | output | 1 | registered echo of a8 |
| bank_active_o | output | 8 | bank has an open row |
| bank_ready_for_act_o | output | 8 | bank may be activated now |
| all_idle_o | output | 1 | every bank ready |
| rd_locked_o | output | 1 | reads barred after self-refresh exit |

## Verification
Single-bank precharge is tried three ways. A redundant second precharge follows it. An early activate follows it. An activate lands exactly on the boundary. Together these separate a restarted countdown from a correct one and expose an off-by-one. A write with auto-precharge is sampled on each side of its close edge and of its ready edge, which tells the deferred close apart from an immediate one. Precharge-all with a mix of open and idle banks shows that the bank address is ignored. Reads to open and idle banks inside and past the self-refresh lockout check the code priority and the exact end of the lockout window.

// File: rtl/bnk_pkg.sv
package bnk_pkg;
    localparam int NUM_BANKS = 8;
    localparam int BA_W      = $clog2(NUM_BANKS);

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_SRE = 3'd6,
        CMD_SRX = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_OPEN,
        BK_WRAP,
        BK_PRECH
    } bank_st_e;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_NOT_IDLE = 3'd1,
        ERR_NOT_OPEN = 3'd2,
        ERR_TRP      = 3'd3,
        ERR_RD_LOCK  = 3'd4
    } err_e;

    typedef struct packed {
        cmd_e            cmd;
        logic [BA_W-1:0] bank;
        logic            a8;
    } cmd_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/bank_slot.sv
module bank_slot
    import bnk_pkg::*;
#(
    parameter int T_RP   = 4,
    parameter int T_WRAP = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic do_act,
    input  logic do_wrap,
    input  logic do_pre,
    output logic open_o,
    output logic ready_o
);
    localparam int CW = $clog2(max_of(T_RP, T_WRAP) + 1);

    bank_st_e        st;
    logic [CW-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= BK_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                BK_IDLE: begin
                    if (do_act) st <= BK_OPEN;
                end
                BK_OPEN: begin
                    if (do_pre) begin
                        st  <= BK_PRECH;
                        cnt <= CW'(T_RP - 1);
                    end else if (do_wrap) begin
                        st  <= BK_WRAP;
                        cnt <= CW'(T_WRAP - 1);
                    end
                end
                BK_WRAP: begin
                    if (cnt == '0) begin
                        st  <= BK_PRECH;
                        cnt <= CW'(T_RP - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                BK_PRECH: begin
                    if (cnt == '0) st <= do_act ? BK_OPEN : BK_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: st <= BK_IDLE;
            endcase
        end
    end

    assign open_o  = (st == BK_OPEN) || ((st == BK_WRAP) && (cnt != '0));
    assign ready_o = (st == BK_IDLE) || ((st == BK_PRECH) && (cnt == '0));
endmodule

// File: rtl/srx_lockout.sv
module srx_lockout #(
    parameter int T_SRX = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic locked_o
);
    localparam int LW = $clog2(T_SRX + 1);

    logic [LW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)               left <= '0;
        else if (start)        left <= LW'(T_SRX - 1);
        else if (left != '0)   left <= left - 1'b1;
    end

    assign locked_o = (left != '0);
endmodule

// File: rtl/cmd_judge.sv
module cmd_judge
    import bnk_pkg::*;
(
    input  cmd_t                 c_i,
    input  logic [NUM_BANKS-1:0] open_i,
    input  logic [NUM_BANKS-1:0] ready_i,
    input  logic                 locked_i,
    output err_e                 code_o,
    output logic [NUM_BANKS-1:0] act_go,
    output logic [NUM_BANKS-1:0] wrap_go,
    output logic [NUM_BANKS-1:0] pre_go,
    output logic                 srx_go
);
    logic sel_open, sel_ready, every_ready;
    logic [NUM_BANKS-1:0] sel_mask;

    assign sel_open    = open_i[c_i.bank];
    assign sel_ready   = ready_i[c_i.bank];
    assign every_ready = &ready_i;

    always_comb begin
        sel_mask = '0;
        sel_mask[c_i.bank] = 1'b1;
    end

    always_comb begin
        code_o  = ERR_NONE;
        act_go  = '0;
        wrap_go = '0;
        pre_go  = '0;
        srx_go  = 1'b0;
        unique case (c_i.cmd)
            CMD_ACT: begin
                if (sel_open)        code_o = ERR_NOT_IDLE;
                else if (!sel_ready) code_o = ERR_TRP;
                else                 act_go = sel_mask;
            end
            CMD_RD: begin
                if (locked_i)        code_o = ERR_RD_LOCK;
                else if (!sel_open)  code_o = ERR_NOT_OPEN;
            end
            CMD_WR: begin
                if (!sel_open)       code_o = ERR_NOT_OPEN;
                else if (c_i.a8)     wrap_go = sel_mask;
            end
            CMD_PRE: begin
                pre_go = c_i.a8 ? open_i : (open_i & sel_mask);
            end
            CMD_REF, CMD_SRE: begin
                if (!every_ready)    code_o = ERR_NOT_IDLE;
            end
            CMD_SRX: srx_go = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker
    import bnk_pkg::*;
#(
    parameter int T_RP   = 4,
    parameter int T_WRAP = 3,
    parameter int T_SRX  = 1000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           cmd_i,
    input  logic [BA_W-1:0]      ba_i,
    input  logic                 a8_i,
    output logic                 err_o,
    output logic [2:0]           err_code_o,
    output logic [2:0]           mon_cmd_o,
    output logic [BA_W-1:0]      mon_ba_o,
    output logic                 mon_a8_o,
    output logic [NUM_BANKS-1:0] bank_active_o,
    output logic [NUM_BANKS-1:0] bank_ready_for_act_o,
    output logic                 all_idle_o,
    output logic                 rd_locked_o
);
    cmd_t                 cur, mon_q;
    err_e                 code, code_q;
    logic [NUM_BANKS-1:0] open_v, ready_v, act_go, wrap_go, pre_go;
    logic                 srx_go, locked;

    assign cur.cmd  = cmd_e'(cmd_i);
    assign cur.bank = ba_i;
    assign cur.a8   = a8_i;

    cmd_judge judge_i (
        .c_i      (cur),
        .open_i   (open_v),
        .ready_i  (ready_v),
        .locked_i (locked),
        .code_o   (code),
        .act_go   (act_go),
        .wrap_go  (wrap_go),
        .pre_go   (pre_go),
        .srx_go   (srx_go)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_slot #(.T_RP(T_RP), .T_WRAP(T_WRAP)) slot_i (
            .clk     (clk),
            .rst     (rst),
            .do_act  (act_go[b]),
            .do_wrap (wrap_go[b]),
            .do_pre  (pre_go[b]),
            .open_o  (open_v[b]),
            .ready_o (ready_v[b])
        );
    end

    srx_lockout #(.T_SRX(T_SRX)) lock_i (
        .clk      (clk),
        .rst      (rst),
        .start    (srx_go),
        .locked_o (locked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= ERR_NONE;
            mon_q  <= '0;
        end else begin
            code_q <= code;
            mon_q  <= cur;
        end
    end

    assign err_o                = (code_q != ERR_NONE);
    assign err_code_o           = code_q;
    assign mon_cmd_o            = mon_q.cmd;
    assign mon_ba_o             = mon_q.bank;
    assign mon_a8_o             = mon_q.a8;
    assign bank_active_o        = open_v;
    assign bank_ready_for_act_o = ready_v;
    assign all_idle_o           = &ready_v;
    assign rd_locked_o          = locked;
endmodule

// File: rtl/dram_bank_tracker_chk.sv
module dram_bank_tracker_chk #(
    parameter int NB    = 8,
    parameter int BW    = 3,
    parameter int T_SRX = 1000
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    cmd_i,
    input logic [BW-1:0] ba_i,
    input logic          a8_i,
    input logic          err_o,
    input logic [2:0]    err_code_o,
    input logic [2:0]    mon_cmd_o,
    input logic [BW-1:0] mon_ba_o,
    input logic          mon_a8_o,
    input logic [NB-1:0] bank_active_o,
    input logic [NB-1:0] bank_ready_for_act_o,
    input logic          all_idle_o,
    input logic          rd_locked_o
);
    assert_act_opens_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 3'd1 && bank_ready_for_act_o[ba_i]) |=> (bank_active_o[$past(ba_i)] && !err_o));

    assert_open_not_ready_R2: assert property (@(posedge clk) disable iff (rst)
        (bank_active_o & bank_ready_for_act_o) == '0);

    assert_act_early_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 3'd1 && !bank_ready_for_act_o[ba_i] && !bank_active_o[ba_i]) |=> (err_code_o == 3'd3));

    assert_pre_silent_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 3'd4) |=> !err_o);

    assert_wr_closed_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 3'd3 && !bank_active_o[ba_i]) |=> (err_code_o == 3'd2));

    assert_ref_busy_R8: assert property (@(posedge clk) disable iff (rst)
        ((cmd_i == 3'd5 || cmd_i == 3'd6) && !all_idle_o) |=> (err_code_o == 3'd1));

    assert_rd_locked_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 3'd2 && rd_locked_o) |=> (err_code_o == 3'd4));

    assert_srx_sets_lock_R9: assert property (@(posedge clk) disable iff (rst)
        (T_SRX > 1 && cmd_i == 3'd7) |=> rd_locked_o);

    assert_mon_echo_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (mon_cmd_o == $past(cmd_i) && mon_ba_o == $past(ba_i) && mon_a8_o == $past(a8_i)));

    assert_idle_means_closed_R12: assert property (@(posedge clk) disable iff (rst)
        all_idle_o |-> (bank_active_o == '0));
endmodule

bind dram_bank_tracker dram_bank_tracker_chk #(
    .NB(bnk_pkg::NUM_BANKS), .BW(bnk_pkg::BA_W), .T_SRX(T_SRX)
) chk_i (
    .clk                  (clk),
    .rst                  (rst),
    .cmd_i                (cmd_i),
    .ba_i                 (ba_i),
    .a8_i                 (a8_i),
    .err_o                (err_o),
    .err_code_o           (err_code_o),
    .mon_cmd_o            (mon_cmd_o),
    .mon_ba_o             (mon_ba_o),
    .mon_a8_o             (mon_a8_o),
    .bank_active_o        (bank_active_o),
    .bank_ready_for_act_o (bank_ready_for_act_o),
    .all_idle_o           (all_idle_o),
    .rd_locked_o          (rd_locked_o)
);

// File: tb/dram_bank_tracker_tb_top.sv
module dram_bank_tracker_tb_top;
    localparam int T_RP   = 4;
    localparam int T_WRAP = 3;
    localparam int T_SRX  = 1000;
    localparam int INF    = 1 << 30;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cmd = 3'd0;
    logic [2:0] ba  = 3'd0;
    logic       a8  = 1'b0;
    logic       err_o, mon_a8_o, all_idle_o, rd_locked_o;
    logic [2:0] err_code_o, mon_cmd_o, mon_ba_o;
    logic [7:0] bank_active_o, bank_ready_for_act_o;

    always #10 clk = ~clk;

    dram_bank_tracker #(.T_RP(T_RP), .T_WRAP(T_WRAP), .T_SRX(T_SRX)) dut_i (
        .clk(clk), .rst(rst), .cmd_i(cmd), .ba_i(ba), .a8_i(a8),
        .err_o(err_o), .err_code_o(err_code_o),
        .mon_cmd_o(mon_cmd_o), .mon_ba_o(mon_ba_o), .mon_a8_o(mon_a8_o),
        .bank_active_o(bank_active_o), .bank_ready_for_act_o(bank_ready_for_act_o),
        .all_idle_o(all_idle_o), .rd_locked_o(rd_locked_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // reference model: per bank, when the row closes and when activate is allowed again
    bit m_open[8];
    int m_close[8];
    int m_idle[8];
    int lock_until = 0;
    int edge_n = -1;
    int x_code = 0, x_cmd = 0, x_ba = 0, x_a8 = 0;

    function automatic bit m_act(input int i, input int t);
        return m_open[i] && (t < m_close[i]);
    endfunction

    function automatic bit m_rdy(input int i, input int t);
        return !m_act(i, t) && (t >= m_idle[i]);
    endfunction

    function automatic string code_tag(input int code, input int c);
        case (code)
            1: return (c == 1) ? "R2" : "R8";
            2: return "R6";
            3: return "R3";
            4: return "R9";
            default: return (c == 4) ? "R5" : "R10";
        endcase
    endfunction

    always @(posedge clk) begin
        int e;
        int c;
        int b;
        bit any_busy;
        edge_n++;
        e = edge_n;
        if (rst) begin
            for (int i = 0; i < 8; i++) begin
                m_open[i] = 0; m_close[i] = INF; m_idle[i] = 0;
            end
            lock_until = 0;
            x_code = 0; x_cmd = 0; x_ba = 0; x_a8 = 0;
        end else begin
            c = int'(cmd); b = int'(ba);
            x_cmd = c; x_ba = b; x_a8 = int'(a8);
            x_code = 0;
            any_busy = 0;
            for (int i = 0; i < 8; i++) if (!m_rdy(i, e)) any_busy = 1;
            case (c)
                1: begin
                    if (m_act(b, e))       x_code = 1;
                    else if (!m_rdy(b, e)) x_code = 3;
                    else begin m_open[b] = 1; m_close[b] = INF; end
                end
                2: begin
                    if (e < lock_until)    x_code = 4;
                    else if (!m_act(b, e)) x_code = 2;
                end
                3: begin
                    if (!m_act(b, e)) x_code = 2;
                    else if (a8 && m_close[b] == INF) begin
                        m_close[b] = e + T_WRAP;
                        m_idle[b]  = e + T_WRAP + T_RP;
                    end
                end
                4: begin
                    for (int i = 0; i < 8; i++) begin
                        if ((a8 || i == b) && m_act(i, e) && m_close[i] == INF) begin
                            m_close[i] = e;
                            m_idle[i]  = e + T_RP;
                        end
                    end
                end
                5, 6: if (any_busy) x_code = 1;
                7: lock_until = e + T_SRX;
                default: ;
            endcase
        end
    end

    always @(negedge clk) begin
        int t;
        bit all_r;
        if (edge_n >= 0 && !done) begin
            t = edge_n + 1;
            all_r = 1;
            for (int i = 0; i < 8; i++) begin
                chk("R2", $sformatf("bank_active[%0d]", i), int'(bank_active_o[i]), int'(m_act(i, t)));
                chk("R3", $sformatf("ready[%0d]", i), int'(bank_ready_for_act_o[i]), int'(m_rdy(i, t)));
                if (!m_rdy(i, t)) all_r = 0;
            end
            chk("R12", "all_idle", int'(all_idle_o), int'(all_r));
            chk("R9", "rd_locked", int'(rd_locked_o), int'(t < lock_until));
            chk(code_tag(x_code, x_cmd), "err_code", int'(err_code_o), x_code);
            chk("R10", "err_o", int'(err_o), int'(x_code != 0));
            chk("R10", "mon_cmd", int'(mon_cmd_o), x_cmd);
            chk("R10", "mon_ba", int'(mon_ba_o), x_ba);
            chk("R10", "mon_a8", int'(mon_a8_o), x_a8);
        end
    end

    task automatic send(input int c, input int b, input bit ap);
        cmd = 3'(c); ba = 3'(b); a8 = ap;
        @(negedge clk);
        cmd = 3'd0; ba = 3'd0; a8 = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "active in reset", int'(bank_active_o), 0);
        chk("R1", "ready in reset", int'(bank_ready_for_act_o), 255);
        chk("R1", "lock in reset", int'(rd_locked_o), 0);
        rst = 1'b0;
        idle(1);
        chk("R1", "all_idle after reset", int'(all_idle_o), 1);
        chk("R1", "err after reset", int'(err_o), 0);

        send(1, 0, 0); chk("R2", "act opens b0", int'(bank_active_o[0]), 1);
        send(1, 1, 0);
        send(1, 0, 0); chk("R2", "act to open bank", int'(err_code_o), 1);
        send(2, 0, 0); chk("R6", "rd open bank ok", int'(err_code_o), 0);
        send(2, 2, 0); chk("R6", "rd idle bank", int'(err_code_o), 2);
        chk("R11", "b2 still ready", int'(bank_ready_for_act_o[2]), 1);
        send(3, 3, 1); chk("R6", "wr idle bank", int'(err_code_o), 2);
        idle(T_WRAP + 1);
        chk("R11", "b3 unaffected", int'(bank_ready_for_act_o[3]), 1);

        send(4, 0, 0);
        chk("R3", "pre closes b0", int'(bank_active_o[0]), 0);
        chk("R3", "b0 not ready", int'(bank_ready_for_act_o[0]), 0);
        send(1, 0, 0); chk("R3", "early act", int'(err_code_o), 3);
        send(4, 0, 0); chk("R5", "redundant pre", int'(err_o), 0);
        idle(T_RP - 3);
        chk("R5", "timer not restarted", int'(bank_ready_for_act_o[0]), 1);
        send(1, 0, 0); chk("R3", "act at boundary", int'(err_code_o), 0);

        send(3, 1, 1); chk("R7", "row open after wr-ap", int'(bank_active_o[1]), 1);
        idle(T_WRAP - 2); chk("R7", "still open", int'(bank_active_o[1]), 1);
        idle(1); chk("R7", "closed", int'(bank_active_o[1]), 0);
        idle(T_RP - 1); chk("R7", "not yet ready", int'(bank_ready_for_act_o[1]), 0);
        idle(1); chk("R7", "ready", int'(bank_ready_for_act_o[1]), 1);

        send(1, 2, 0);
        send(1, 5, 0);
        send(6, 0, 0); chk("R8", "sre with open rows", int'(err_code_o), 1);
        send(4, 6, 1);
        chk("R4", "all rows closed", int'(bank_active_o), 0);
        chk("R4", "ready map", int'(bank_ready_for_act_o), 8'hDA);
        chk("R10", "mon bank", int'(mon_ba_o), 6);
        send(5, 0, 0); chk("R8", "ref while closing", int'(err_code_o), 1);
        idle(T_RP);
        chk("R12", "all idle", int'(all_idle_o), 1);
        send(5, 0, 0); chk("R8", "ref idle ok", int'(err_code_o), 0);

        send(6, 0, 0); chk("R8", "sre idle ok", int'(err_code_o), 0);
        send(7, 0, 0); chk("R9", "locked", int'(rd_locked_o), 1);
        send(1, 0, 0);
        send(2, 0, 0); chk("R9", "rd locked", int'(err_code_o), 4);
        send(2, 3, 0); chk("R9", "lock over not-active", int'(err_code_o), 4);
        idle(T_SRX - 5); chk("R9", "lock last cycle", int'(rd_locked_o), 1);
        idle(1); chk("R9", "lock over", int'(rd_locked_o), 0);
        send(2, 0, 0); chk("R9", "rd after lock", int'(err_code_o), 0);
        idle(4);
        finish_run();
    end
endmodule